// File: doc/BRIEF.md
# Dead-Band Generator for a Complementary PWM Pair

This block sits between a PWM waveform generator and a pair of power-switch gate drivers. It takes two raw PWM signals, A and B, and builds from them a complementary pair with a guard interval around each transition, so that the upper and lower switches of a half-bridge are never on together. Two independent delay paths do the work. The rising-edge path holds back low-to-high transitions of its source. The falling-edge path holds back high-to-low transitions of its source. Each path has its own delay count.

Three small control fields shape the pair. One picks which raw input feeds each delay path. One picks whether each delayed path is inverted. One picks whether each output takes its delayed path or bypasses it. With these fields the block can produce active-high complementary pairs, active-low complementary pairs, or a plain pass-through. Software sets the fields and the two counts through a small synchronous write port. All logic runs on the delay clock, and the delay in time is the count divided by the clock frequency. For example, a count of 160 at 50 MHz gives 3.2 µs.

Top module: `dead_band_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it, both outputs are 0. Reset clears the control word and both delay counts to 0, so the block starts in bypass.
- R2: With output mode 00, each output equals its own raw input as sampled at the previous clock edge. The polarity and input-source fields have no effect in this mode.
- R3: The rising-edge path goes high only after its source has been sampled high on D_rise+1 consecutive edges. It goes low on the first edge that samples the source low. A count of 0 makes the path equal to the registered source.
- R4: The falling-edge path goes low only after its source has been sampled low on D_fall+1 consecutive edges. It goes high on the first edge that samples the source high.
- R5: A source pulse that lasts D or fewer samples never appears on that delayed path. A high pulse is swallowed by the rising path, and a low pulse is swallowed by the falling path.
- R6: Output mode is control bits [1:0]. Bit 1 routes output A from the rising-edge path, and otherwise A is bypassed. Bit 0 routes output B from the falling-edge path, and otherwise B is bypassed. So 11 uses both paths, 10 delays only A, and 01 delays only B.
- R7: Polarity is control bits [3:2]. Bit 2 inverts the rising-edge path feeding A, and bit 3 inverts the falling-edge path feeding B. So 00 inverts neither, 01 inverts A, 10 inverts B, and 11 inverts both.
- R8: Input mode is control bits [5:4]. Bit 4 set makes raw B the rising-path source, otherwise raw A. Bit 5 set makes raw B the falling-path source, otherwise raw A. So 00 is A for both, 01 is rising from B and falling from A, 10 is rising from A and falling from B, and 11 is B for both.
- R9: A write to address 1 loads the 10-bit rising count, and a write to address 2 loads the 10-bit falling count. The two counts are independent. A count of 160 delays the edge by exactly 160 clock cycles, and the full count of 1023 works without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Delay clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register address: 0 control word, 1 rising count, 2 falling count |
| cfg_wdata | input | 10 | Write data; the control word uses bits [5:0] |
| pwm_a_in | input | 1 | Raw PWM signal A |
| pwm_b_in | input | 1 | Raw PWM signal B |
| pwm_a_out | output | 1 | Processed output A |
| pwm_b_out | output | 1 | Processed output B |

## Verification
Raw inputs reach a bypassed output one edge after they are sampled. A delayed rising edge on A appears D_rise edges later than that, and a delayed falling edge on B appears D_fall edges later. Removal edges appear with no added delay. A configuration write takes effect on the edge that samples the strobe. The bench drives all inputs on the falling clock edge. A behavioural model counts run lengths of each selected source at every rising edge, and the outputs are compared with it 1 ns after each rising edge, once the registers have settled. A directed measurement also counts falling edges from an input step to the delayed output rise, to confirm the 160-cycle case exactly.

// File: rtl/db_pkg.sv
package db_pkg;

    localparam int DB_DLY_W = 10;
    localparam int DB_ADDR_W = 2;

    typedef enum logic [1:0] {
        OM_BYPASS    = 2'b00,
        OM_FALL_ONLY = 2'b01,
        OM_RISE_ONLY = 2'b10,
        OM_BOTH      = 2'b11
    } db_outmode_e;

    typedef enum logic [DB_ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_RISE = 2'd1,
        REG_FALL = 2'd2,
        REG_NONE = 2'd3
    } db_addr_e;

    // Packed control word: in_sel at [5:4], pol at [3:2], out_mode at [1:0]
    typedef struct packed {
        logic [1:0]  in_sel;
        logic [1:0]  pol;
        db_outmode_e out_mode;
    } db_ctrl_t;

    localparam int DB_CTRL_W = $bits(db_ctrl_t);

    // Source pick for one delay path: 0 selects raw A, 1 selects raw B
    function automatic logic db_pick(input logic sel_b, input logic a, input logic b);
        return sel_b ? b : a;
    endfunction

endpackage

// File: rtl/db_cfg_regs.sv
module db_cfg_regs
    import db_pkg::*;
#(
    parameter int DLY_W  = DB_DLY_W,
    parameter int ADDR_W = DB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DLY_W-1:0]  wdata,
    output db_ctrl_t          ctrl,
    output logic [DLY_W-1:0]  rise_dly,
    output logic [DLY_W-1:0]  fall_dly
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            rise_dly <= '0;
            fall_dly <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_CTRL: ctrl     <= db_ctrl_t'(wdata[DB_CTRL_W-1:0]);
                REG_RISE: rise_dly <= wdata;
                REG_FALL: fall_dly <= wdata;
                default:  ;
            endcase
        end
    end

    p_rise_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_RISE) |=> (rise_dly == $past(wdata)));

    p_fall_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_FALL) |=> (fall_dly == $past(wdata)));

endmodule

// File: rtl/db_edge_delay.sv
module db_edge_delay
    import db_pkg::*;
#(
    parameter int DLY_W     = DB_DLY_W,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [DLY_W-1:0] dly,
    output logic             dout
);

    localparam int CNT_W = DLY_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << DLY_W;

    logic             act;      // source level that is held back
    logic [CNT_W-1:0] run_q;    // consecutive active samples, saturating
    logic             hit;

    assign act = FALL_EDGE ? ~din : din;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            run_q <= '0;
        end else if (run_q != CNT_MAX) begin
            run_q <= run_q + CNT_W'(1);
        end
    end

    assign hit  = run_q > {1'b0, dly};
    assign dout = FALL_EDGE ? ~hit : hit;

    // Any inactive sample removes the delayed level on the next edge (R3/R4/R5)
    p_drop_on_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !act |=> !hit);

    // Delayed level only follows an active sample
    p_needs_source_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(act));

    // Once asserted it stays while the source stays and the count is unchanged
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && act) |=> (hit || !$stable(dly)));

endmodule

// File: rtl/db_out_stage.sv
module db_out_stage
    import db_pkg::*;
(
    input  db_ctrl_t ctrl,
    input  logic     a_q,
    input  logic     b_q,
    input  logic     rise_path,
    input  logic     fall_path,
    output logic     out_a,
    output logic     out_b
);

    logic rise_pol;
    logic fall_pol;

    always_comb begin
        rise_pol = rise_path ^ ctrl.pol[0];
        fall_pol = fall_path ^ ctrl.pol[1];
        out_a    = ctrl.out_mode[1] ? rise_pol : a_q;
        out_b    = ctrl.out_mode[0] ? fall_pol : b_q;
    end

endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen
    import db_pkg::*;
#(
    parameter int DLY_W  = DB_DLY_W,
    parameter int ADDR_W = DB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DLY_W-1:0]  cfg_wdata,
    input  logic              pwm_a_in,
    input  logic              pwm_b_in,
    output logic              pwm_a_out,
    output logic              pwm_b_out
);

    localparam int NPATH = 2;   // index 0 rising-edge path, 1 falling-edge path

    db_ctrl_t         ctrl;
    logic [DLY_W-1:0] rise_dly;
    logic [DLY_W-1:0] fall_dly;
    logic             a_q;
    logic             b_q;
    logic             src_v  [NPATH];
    logic [DLY_W-1:0] dly_v  [NPATH];
    logic             path_v [NPATH];

    db_cfg_regs #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .ctrl     (ctrl),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= pwm_a_in;
            b_q <= pwm_b_in;
        end
    end

    assign dly_v[0] = rise_dly;
    assign dly_v[1] = fall_dly;

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        assign src_v[g] = db_pick(ctrl.in_sel[g], pwm_a_in, pwm_b_in);

        db_edge_delay #(.DLY_W(DLY_W), .FALL_EDGE(g == 1)) u_dly (
            .clk  (clk),
            .rst  (rst),
            .din  (src_v[g]),
            .dly  (dly_v[g]),
            .dout (path_v[g])
        );
    end

    db_out_stage u_out (
        .ctrl      (ctrl),
        .a_q       (a_q),
        .b_q       (b_q),
        .rise_path (path_v[0]),
        .fall_path (path_v[1]),
        .out_a     (pwm_a_out),
        .out_b     (pwm_b_out)
    );

    p_bypass_a_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ctrl.out_mode == OM_BYPASS) |-> (pwm_a_out == $past(pwm_a_in)));

    p_bypass_b_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ctrl.out_mode == OM_BYPASS) |-> (pwm_b_out == $past(pwm_b_in)));

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pwm_a_out && !pwm_b_out));

endmodule

// File: tb/dead_band_gen_bench.sv
module dead_band_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [9:0] cfg_wdata = '0;
    logic       pwm_a_in = 1'b0;
    logic       pwm_b_in = 1'b0;
    logic       pwm_a_out;
    logic       pwm_b_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    dead_band_gen u_dead_band_gen (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pwm_a_in  (pwm_a_in),
        .pwm_b_in  (pwm_b_in),
        .pwm_a_out (pwm_a_out),
        .pwm_b_out (pwm_b_out)
    );

    // Behavioural reference: run lengths of the selected sources
    int       run_hi = 0;
    int       run_lo = 0;
    bit       m_a = 0, m_b = 0;
    bit [1:0] m_mode = 0, m_pol = 0, m_in = 0;
    int       m_rd = 0, m_fd = 0;

    always @(posedge clk) begin
        bit rs, fs;
        if (rst) begin
            run_hi = 0; run_lo = 0; m_a = 0; m_b = 0;
            m_mode = 0; m_pol = 0; m_in = 0; m_rd = 0; m_fd = 0;
        end else begin
            rs = m_in[0] ? pwm_b_in : pwm_a_in;
            fs = m_in[1] ? pwm_b_in : pwm_a_in;
            run_hi = rs ? ((run_hi < 5000) ? run_hi + 1 : run_hi) : 0;
            run_lo = !fs ? ((run_lo < 5000) ? run_lo + 1 : run_lo) : 0;
            m_a = pwm_a_in;
            m_b = pwm_b_in;
            if (cfg_wr_en) begin
                case (cfg_addr)
                    2'd0: begin m_mode = cfg_wdata[1:0]; m_pol = cfg_wdata[3:2]; m_in = cfg_wdata[5:4]; end
                    2'd1: m_rd = int'(cfg_wdata);
                    2'd2: m_fd = int'(cfg_wdata);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit red, fed, ea, eb;
        #1;
        if (!rst && !done) begin
            red = run_hi > m_rd;
            fed = !(run_lo > m_fd);
            ea  = m_mode[1] ? (red ^ m_pol[0]) : m_a;
            eb  = m_mode[0] ? (fed ^ m_pol[1]) : m_b;
            check("out_a", pwm_a_out, ea);
            check("out_b", pwm_b_out, eb);
        end
    end

    task automatic wr(input logic [1:0] ad, input logic [9:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ctrl(input logic [1:0] inm, input logic [1:0] pol, input logic [1:0] om);
        wr(2'd0, {4'b0, inm, pol, om});
    endtask

    task automatic drive(input logic a, input logic b, input int n);
        @(negedge clk);
        pwm_a_in = a; pwm_b_in = b;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(1, 12)));
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running expected finished");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("reset out_a", pwm_a_out, 1'b0);
        check("reset out_b", pwm_b_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("post-reset out_a", pwm_a_out, 1'b0);
        check("post-reset out_b", pwm_b_out, 1'b0);

        // R2: bypass, with the other fields set to non-zero values
        cur_req = "R2";
        wr(2'd1, 10'd9); wr(2'd2, 10'd9);
        ctrl(2'b11, 2'b11, 2'b00);
        random_run(40);

        // R3/R4: both paths, classical source, zero delay then nonzero
        cur_req = "R3";
        wr(2'd1, 10'd0); wr(2'd2, 10'd0);
        ctrl(2'b00, 2'b00, 2'b11);
        random_run(30);
        wr(2'd1, 10'd5); wr(2'd2, 10'd7);
        cur_req = "R4";
        for (int i = 0; i < 4; i++) begin drive(1, 0, 20); drive(0, 0, 20); end

        // R5: short pulses swallowed
        cur_req = "R5";
        wr(2'd1, 10'd6); wr(2'd2, 10'd6);
        drive(0, 0, 20);
        for (int i = 0; i < 4; i++) begin
            drive(1, 0, 6);
            drive(0, 0, 10);
            check("short high pulse swallowed", pwm_a_out, 1'b0);
        end
        drive(1, 0, 20);
        for (int i = 0; i < 4; i++) begin
            drive(0, 0, 5);
            drive(1, 0, 10);
            check("short low pulse swallowed", pwm_b_out, 1'b1);
        end

        // R6: single-path modes
        cur_req = "R6";
        wr(2'd1, 10'd3); wr(2'd2, 10'd4);
        ctrl(2'b00, 2'b00, 2'b01);
        random_run(30);
        ctrl(2'b00, 2'b00, 2'b10);
        random_run(30);

        // R7: every polarity code
        cur_req = "R7";
        for (int p = 0; p < 4; p++) begin
            ctrl(2'b00, 2'(p), 2'b11);
            random_run(25);
        end

        // R8: every input-source code with independent A/B
        cur_req = "R8";
        for (int m = 0; m < 4; m++) begin
            ctrl(2'(m), 2'b00, 2'b11);
            random_run(30);
            drive(1, 0, 15); drive(0, 1, 15);
        end

        // R9: count 160 measured directly, full count 1023
        cur_req = "R9";
        ctrl(2'b00, 2'b00, 2'b10);
        wr(2'd1, 10'd160);
        drive(0, 0, 10);
        begin
            int n;
            n = 0;
            @(negedge clk);
            pwm_a_in = 1'b1;
            do begin @(negedge clk); n++; end while (pwm_a_out == 1'b0 && n < 400);
            checks++;
            if (n != 161) begin
                errors++;
                $display("FAIL R9 delay160 got %0d expected %0d", n, 161);
            end
        end
        drive(0, 0, 10);
        ctrl(2'b00, 2'b00, 2'b11);
        wr(2'd2, 10'd1023);
        for (int i = 0; i < 2; i++) begin drive(1, 0, 1200); drive(0, 0, 1200); end
        drive(1, 0, 1030);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule